// File: doc/BRIEF.md
# Programmable Power-of-Two Clock Divider

This block takes a reference clock and produces, for each of several channels, a clock divided by a power of two. Software sets the ratio with a 3-bit factor (ratio = 2^(factor-1), a factor of 0 behaving as 1). It starts or stops the output with an enable bit. Both live in a byte-wide register page that belongs to the channel. Channel pages follow one another at a stride of 256 bytes from a base page. A write to a register takes effect on the next reference clock edge. Reads are combinational from the address.

The enable request crosses a two-flop synchronizer. A small sequencer then starts and stops the output only on phase boundaries, so every high phase the block emits has full width. For ratios of 2 and above, the output is a registered toggle driven by a half-period counter. For ratio 1, the output is the reference itself, gated by a flop that changes while the reference is low. A per-channel running flag tells the system when the gated output is live. The factor is sampled when the output starts, so a factor written while running is held off until the next start. The intended way to change ratio is to disable, wait for the stop, write the factor and enable again.

Top module: `pow2_clkdiv`

## Requirements
- R1: After reset, every channel reads factor 0 and enable 0, and every div_clk and div_running output is low.
- R2: The factor register is at page offset 0x43. Bits [2:0] hold the factor and read back as written. Bits [7:3] are ignored on write and read as 0.
- R3: The enable request is bit 7 of the register at page offset 0x46 and reads back as written. Bits [6:0] are ignored on write, read as 0, and do not start the output.
- R4: For factor f in 2..7, the running output is high for 2^(f-2) reference cycles and then low for 2^(f-2) reference cycles, so its ratio is 2^(f-1).
- R5: For factor 0 or 1, the running output follows the reference clock: it is high during every high phase of the reference.
- R6: Counted in reference cycles from the edge that stores the enable write, div_clk is high and div_running is 1 within 2 + 3×ratio cycles.
- R7: Counted from the edge that stores the disable write, div_clk is low and div_running is 0 within 3×ratio cycles. Both then stay low.
- R8: For ratios of 2 and above, the first high phase after a start and the last high phase before a stop both last the full half period.
- R9: A factor written while a channel is running reads back at once but does not change that channel's output until the channel is disabled and enabled again.
- R10: Channel i decodes page BASE_PAGE + i (address bits [15:8]). A write to one channel's page leaves the other channels unchanged. Pages outside the channel range, and offsets other than 0x43 and 0x46, read as 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address: page in the upper bits, offset in bits [7:0] |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising reference edge |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| div_clk | output | NCH | Divided, gated clock per channel |
| div_running | output | NCH | High while the channel's output is started |

## Verification
The hardest case to reach from the ports is a disable that arrives partway through a high phase. The stop must then wait for that phase to finish at full width and still meet the 3×ratio bound. The stimulus reaches it by running every factor from 0 to 7 through a full enable, sample and disable cycle. Because the bus write lands at differing points in the toggle phase, some stops land mid-phase. A monitor records the length of the last high run so that truncation is caught. A second scenario writes a new factor while running and then re-enables, to show that the captured ratio is held and then replaced.

// File: rtl/pow2div_pkg.sv
`timescale 1ns/1ps
package pow2div_pkg;

    localparam int FACT_W     = 3;
    localparam int DATA_W     = 8;
    localparam int OFF_W      = 8;
    localparam int MAX_FACT   = (1 << FACT_W) - 1;
    localparam int CNT_W      = MAX_FACT - 1;   // holds half period of the largest ratio
    localparam logic [OFF_W-1:0] OFF_FACTOR = 8'h43;
    localparam logic [OFF_W-1:0] OFF_ENABLE = 8'h46;
    localparam int EN_BIT     = 7;

    typedef struct packed {
        logic              en;
        logic [FACT_W-1:0] factor;
    } chan_cfg_t;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_t;

    // factor 0 and 1 both mean the reference passes undivided
    function automatic logic is_bypass(input logic [FACT_W-1:0] f);
        return (f <= FACT_W'(1));
    endfunction

    // half period in reference cycles for ratios of two and above
    function automatic logic [CNT_W-1:0] half_of(input logic [FACT_W-1:0] f);
        if (is_bypass(f))
            return '0;
        return CNT_W'(1) << (f - FACT_W'(2));
    endfunction

endpackage

// File: rtl/pow2div_regs.sv
`timescale 1ns/1ps
module pow2div_regs
    import pow2div_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output chan_cfg_t         cfg,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAGE_W = ADDR_W - OFF_W;

    logic             hit;
    logic [OFF_W-1:0] offset;
    logic             unused_wbits;

    assign hit          = (addr[ADDR_W-1:OFF_W] == PAGE_W'(PAGE));
    assign offset       = addr[OFF_W-1:0];
    assign unused_wbits = ^wdata[EN_BIT-1:FACT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we && hit) begin
            if (offset == OFF_FACTOR)
                cfg.factor <= wdata[FACT_W-1:0];
            if (offset == OFF_ENABLE)
                cfg.en <= wdata[EN_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            if (offset == OFF_FACTOR)
                rdata[FACT_W-1:0] = cfg.factor;
            else if (offset == OFF_ENABLE)
                rdata[EN_BIT] = cfg.en;
        end
    end

endmodule

// File: rtl/pow2div_sync.sv
`timescale 1ns/1ps
module pow2div_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pow2div_core.sv
`timescale 1ns/1ps
module pow2div_core
    import pow2div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_s,
    input  logic [FACT_W-1:0] factor,
    output logic              clk_o,
    output logic              running
);

    run_state_t        state;
    logic [FACT_W-1:0] fact_q;
    logic [CNT_W-1:0]  half_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              bypass_q;
    logic              tog_q;
    logic              gate_q;
    logic              half_end;

    assign half_end = (cnt_q == half_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OFF;
            fact_q   <= '0;
            half_q   <= '0;
            bypass_q <= 1'b1;
            cnt_q    <= '0;
            tog_q    <= 1'b0;
        end else begin
            case (state)
                ST_OFF: begin
                    cnt_q <= '0;
                    tog_q <= 1'b0;
                    if (en_s) begin
                        state    <= ST_RUN;
                        fact_q   <= factor;
                        half_q   <= half_of(factor);
                        bypass_q <= is_bypass(factor);
                        tog_q    <= !is_bypass(factor);
                    end
                end
                ST_RUN: begin
                    if (bypass_q) begin
                        if (!en_s)
                            state <= ST_OFF;
                    end else if (!en_s && !tog_q) begin
                        state <= ST_OFF;
                        cnt_q <= '0;
                    end else if (half_end) begin
                        cnt_q <= '0;
                        tog_q <= ~tog_q;
                        if (!en_s)
                            state <= ST_OFF;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // bypass gate moves only while the reference is low
    always_ff @(negedge clk) begin
        if (rst)
            gate_q <= 1'b0;
        else
            gate_q <= en_s && ((state == ST_RUN) ? bypass_q : is_bypass(factor));
    end

    assign clk_o   = bypass_q ? (clk & gate_q) : tog_q;
    assign running = (state == ST_RUN);

endmodule

// File: rtl/pow2_clkdiv.sv
`timescale 1ns/1ps
module pow2_clkdiv
    import pow2div_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int ADDR_W      = 16,
    parameter int BASE_PAGE   = 'h50,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    div_clk,
    output logic [NCH-1:0]    div_running
);

    logic [DATA_W-1:0] rd_arr [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_cfg_t cfg;
        logic      en_s;

        pow2div_regs #(
            .ADDR_W (ADDR_W),
            .PAGE   (BASE_PAGE + i)
        ) u_regs (
            .clk   (clk),
            .rst   (rst),
            .addr  (bus_addr),
            .we    (bus_we),
            .wdata (bus_wdata),
            .cfg   (cfg),
            .rdata (rd_arr[i])
        );

        pow2div_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (cfg.en),
            .q   (en_s)
        );

        pow2div_core u_core (
            .clk     (clk),
            .rst     (rst),
            .en_s    (en_s),
            .factor  (cfg.factor),
            .clk_o   (div_clk[i]),
            .running (div_running[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++)
            bus_rdata = bus_rdata | rd_arr[i];
    end

endmodule

// File: rtl/pow2div_chk.sv
`timescale 1ns/1ps
module pow2div_chk
    import pow2div_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en_s,
    input logic              running,
    input logic              tog,
    input logic              bypass,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  half,
    input logic [FACT_W-1:0] fact
);

    // R6: a synchronized request starts an idle channel on the next edge
    a_r6_start: assert property (@(posedge clk) disable iff (rst)
        (!running && en_s) |=> running);

    // R7: a channel keeps running while the request stays set
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (running && en_s) |=> running);

    // R8: a divided start begins with the output high
    a_r8_start_high: assert property (@(posedge clk) disable iff (rst)
        ($rose(running) && !bypass) |-> tog);

    // R8: stopping leaves the output low
    a_r8_stop_low: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> !tog);

    // R9: the captured factor holds for the whole run
    a_r9_fact_stable: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> $stable(fact));

    // R4: the half-period counter stays inside its window
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        (running && !bypass) |-> (cnt < half));

endmodule

bind pow2div_core pow2div_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_s    (en_s),
    .running (running),
    .tog     (tog_q),
    .bypass  (bypass_q),
    .cnt     (cnt_q),
    .half    (half_q),
    .fact    (fact_q)
);

// File: tb/sim_pow2_clkdiv.sv
`timescale 1ns/1ps
module sim_pow2_clkdiv;

    localparam int NCH       = 2;
    localparam int ADDR_W    = 16;
    localparam int BASE_PAGE = 'h50;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              we = 1'b0;
    logic [7:0]        rdata;
    logic [NCH-1:0]    dclk;
    logic [NCH-1:0]    drun;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_hi [NCH];
    int last_hi[NCH];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pow2_clkdiv #(
        .NCH       (NCH),
        .ADDR_W    (ADDR_W),
        .BASE_PAGE (BASE_PAGE)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (addr),
        .bus_wdata   (wdata),
        .bus_we      (we),
        .bus_rdata   (rdata),
        .div_clk     (dclk),
        .div_running (drun)
    );

    // records the length of the most recent complete high run per channel
    initial begin
        for (int c = 0; c < NCH; c++) begin
            cur_hi[c]  = 0;
            last_hi[c] = 0;
        end
        forever begin
            @(posedge clk);
            #4;
            for (int c = 0; c < NCH; c++) begin
                if (dclk[c]) begin
                    cur_hi[c]++;
                end else begin
                    if (cur_hi[c] > 0) last_hi[c] = cur_hi[c];
                    cur_hi[c] = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [ADDR_W-1:0] addr_of(input int pg, input int off);
        return ADDR_W'(((BASE_PAGE + pg) << 8) | off);
    endfunction

    function automatic int ratio_of(input int f);
        return (f <= 1) ? 1 : (1 << (f - 1));
    endfunction

    task automatic bus_write(input int pg, input int off, input int d);
        addr  = addr_of(pg, off);
        wdata = 8'(d);
        we    = 1'b1;
        tick();
        we    = 1'b0;
    endtask

    task automatic bus_read(input int pg, input int off, output int v);
        addr = addr_of(pg, off);
        #1;
        v = int'(rdata);
    endtask

    task automatic wait_stop(input int ch);
        int n = 0;
        while ((dclk[ch] || drun[ch]) && n < 300) begin
            tick();
            n++;
        end
        repeat (4) tick();
    endtask

    task automatic measure_runs(input int ch, input int half, input int cycles,
                                output int bad, output int runs);
        logic level;
        int   len;
        bit   first;
        level = dclk[ch];
        len   = 0;
        first = 1'b1;
        bad   = 0;
        runs  = 0;
        repeat (cycles) begin
            tick();
            if (dclk[ch] == level) begin
                len++;
            end else begin
                if (!first) begin
                    runs++;
                    if (len != half) bad++;
                end
                first = 1'b0;
                level = dclk[ch];
                len   = 1;
            end
        end
    endtask

    task automatic t_reset();
        int v;
        for (int c = 0; c < NCH; c++) begin
            bus_read(c, 'h43, v);
            check(v == 0, "R1 factor after reset", v, 0);
            bus_read(c, 'h46, v);
            check(v == 0, "R1 enable after reset", v, 0);
        end
        check(dclk == '0, "R1 div_clk after reset", int'(dclk), 0);
        check(drun == '0, "R1 div_running after reset", int'(drun), 0);
    endtask

    task automatic t_fields();
        int v;
        int hi;
        bus_write(0, 'h43, 'hFD);
        bus_read(0, 'h43, v);
        check(v == 'h05, "R2 factor keeps bits [2:0] only", v, 'h05);
        bus_write(0, 'h43, 'h00);
        bus_write(0, 'h46, 'h7F);
        bus_read(0, 'h46, v);
        check(v == 0, "R3 low enable bits ignored", v, 0);
        hi = 0;
        repeat (12) begin
            tick();
            if (drun[0] || dclk[0]) hi++;
        end
        check(hi == 0, "R3 low enable bits do not start output", hi, 0);
        bus_write(0, 'h46, 'h80);
        bus_read(0, 'h46, v);
        check(v == 'h80, "R3 enable bit 7 readback", v, 'h80);
        bus_write(0, 'h46, 'h00);
        bus_read(0, 'h46, v);
        check(v == 0, "R3 enable cleared readback", v, 0);
        wait_stop(0);
    endtask

    task automatic t_ratio(input int ch, input int f);
        int r;
        int half;
        int n;
        int hi;
        int fl;
        int bad;
        int runs;
        r    = ratio_of(f);
        half = r / 2;
        bus_write(ch, 'h43, f);
        bus_write(ch, 'h46, 'h80);
        n = 0;
        while (!(dclk[ch] && drun[ch]) && n < 300) begin
            tick();
            n++;
        end
        check(n <= 2 + 3 * r, $sformatf("R6 enable latency f=%0d", f), n, 2 + 3 * r);
        if (r == 1) begin
            hi = 0;
            repeat (40) begin
                tick();
                if (dclk[ch]) hi++;
            end
            check(hi == 40, $sformatf("R5 undivided output f=%0d", f), hi, 40);
        end else begin
            fl = 1;
            tick();
            while (dclk[ch] && fl < 200) begin
                fl++;
                tick();
            end
            check(fl == half, $sformatf("R8 first high width f=%0d", f), fl, half);
            measure_runs(ch, half, 8 * r + 16, bad, runs);
            check(bad == 0 && runs >= 4, $sformatf("R4 phase widths f=%0d", f), bad, 0);
        end
        bus_write(ch, 'h46, 'h00);
        n = 0;
        while ((dclk[ch] || drun[ch]) && n < 300) begin
            tick();
            n++;
        end
        check(n <= 3 * r, $sformatf("R7 stop latency f=%0d", f), n, 3 * r);
        hi = 0;
        repeat (3 * r + 4) begin
            tick();
            if (dclk[ch] || drun[ch]) hi++;
        end
        check(hi == 0, $sformatf("R7 stays stopped f=%0d", f), hi, 0);
        if (r > 1)
            check(last_hi[ch] == half, $sformatf("R8 last high width f=%0d", f),
                  last_hi[ch], half);
    endtask

    task automatic t_hold();
        int v;
        int n;
        int bad;
        int runs;
        bus_write(0, 'h43, 3);
        bus_write(0, 'h46, 'h80);
        n = 0;
        while (!drun[0] && n < 50) begin
            tick();
            n++;
        end
        bus_write(0, 'h43, 6);
        bus_read(0, 'h43, v);
        check(v == 6, "R9 factor readback while running", v, 6);
        measure_runs(0, 2, 40, bad, runs);
        check(bad == 0 && runs >= 4, "R9 running ratio held", bad, 0);
        bus_write(0, 'h46, 'h00);
        wait_stop(0);
        bus_write(0, 'h46, 'h80);
        n = 0;
        while (!drun[0] && n < 50) begin
            tick();
            n++;
        end
        measure_runs(0, 16, 140, bad, runs);
        check(bad == 0 && runs >= 4, "R9 new ratio after re-enable", bad, 0);
        bus_write(0, 'h46, 'h00);
        wait_stop(0);
    endtask

    task automatic t_pages();
        int v;
        int hi;
        int bad;
        int runs;
        bus_write(NCH, 'h46, 'h80);
        bus_write(0, 'h44, 'h80);
        bus_write(1, 'h45, 'hFF);
        hi = 0;
        repeat (10) begin
            tick();
            if (drun != '0 || dclk != '0) hi++;
        end
        check(hi == 0, "R10 stray writes start nothing", hi, 0);
        bus_read(NCH, 'h46, v);
        check(v == 0, "R10 page beyond channels reads 0", v, 0);
        bus_read(1, 'h44, v);
        check(v == 0, "R10 unmapped offset reads 0", v, 0);
        bus_write(0, 'h43, 1);
        bus_write(1, 'h43, 2);
        bus_write(1, 'h46, 'h80);
        bus_read(0, 'h43, v);
        check(v == 1, "R10 channel 0 factor untouched", v, 1);
        bus_read(0, 'h46, v);
        check(v == 0, "R10 channel 0 enable untouched", v, 0);
        hi = 0;
        repeat (30) begin
            tick();
            if (drun[0] || dclk[0]) hi++;
        end
        check(hi == 0, "R10 channel 0 stays stopped", hi, 0);
        measure_runs(1, 1, 30, bad, runs);
        check(bad == 0 && runs >= 4 && drun[1], "R10 channel 1 runs by ratio 2", bad, 0);
        bus_write(1, 'h46, 'h00);
        wait_stop(1);
    endtask

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_fields();
        for (int f = 0; f < 8; f++)
            t_ratio(0, f);
        t_ratio(1, 7);
        t_hold();
        t_pages();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R6 watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule